// File: doc/BRIEF.md
# Asynchronous Memory Write Phase Sequencer

This block runs single write cycles to an external asynchronous static RAM or NOR-style memory. A host raises a request that carries an address and a data word, together with a 24-bit timing word. The block captures all three when it accepts the request. It then steps the memory pins through a fixed series of timed phases: address setup, an optional address hold, the write strobe, data hold and bus turnaround. When the turnaround ends, the block returns to idle and pulses an acknowledge for one cycle.

Every phase has its own cycle count, and the counts are encoded in different ways. Address setup counts directly, and a zero setting removes the phase. Address hold and the strobe count directly, and a zero setting is raised to one cycle. Data hold and turnaround always add one to the field value. A two-bit mode field selects which modes include the address-hold phase. Output-enable is never asserted, because the block only writes.

Top module: `async_wr_seq`

## Requirements
- R1: Out of reset, and whenever no cycle is running, cs_n, we_n, oe_n and adv_n are high, and data_oe and ack are low.
- R2: The address-setup phase takes timing[19:16] cycles and a setting of 0 removes it. During address setup, cs_n and adv_n are low and we_n is high.
- R3: The address-hold phase runs only when the mode field timing[1:0] is 2 or 3. It takes timing[23:20] cycles, a setting of 0 counts as 1, and adv_n stays low during it. In modes 0 and 1 the phase is absent, whatever timing[23:20] holds.
- R4: The strobe phase takes timing[11:4] cycles, and a setting of 0 counts as 1. we_n is low only during this phase.
- R5: The data-hold phase takes timing[3:2]+1 cycles and follows the strobe. data_oe is high exactly during the strobe and data-hold phases.
- R6: The turnaround phase takes timing[15:12]+1 cycles and holds cs_n high. On the cycle after it ends, ack is high for one cycle and the block is idle.
- R7: The timing word is sampled only when a request is accepted. A change to it during a running cycle does not alter that cycle.
- R8: The address and data are captured at acceptance. addr_o holds the captured address while cs_n is low, and data_o carries the captured data while we_n is low.
- R9: A request is accepted only in idle with ack low. A request held high through a cycle does not restart it before ack. oe_n stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host write request, held until ack |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| timing | input | 24 | Timing and mode word, sampled at acceptance |
| ack | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Memory chip select, active low |
| we_n | output | 1 | Memory write enable, active low |
| oe_n | output | 1 | Memory output enable, active low (held high) |
| adv_n | output | 1 | Address valid, active low |
| addr_o | output | AW | Memory address bus |
| data_o | output | DW | Memory data bus value |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bound checker tests the pin relations on every cycle. The strobe always lies inside chip select and is always driven. Address valid never overlaps the strobe or the data drive. The bus is released on the cycle chip select rises. The address stays stable while chip select is low, ack is a single-cycle pulse, and data drive outlasts the strobe by at least one cycle. Only the bench's scenarios can show the exact length of each phase for each field encoding: the zero-setting cases, the mode-dependent address hold, sampling of the timing word at acceptance, and a held request not restarting a cycle.

// File: rtl/awseq_pkg.sv
package awseq_pkg;

   localparam int CFG_W = 24;
   localparam int CNT_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_AHOLD,
      PH_STROBE,
      PH_DHOLD,
      PH_TURN
   } phase_e;

   // Timing word layout, most significant field first.
   typedef struct packed {
      logic [3:0] ahold;   // [23:20]
      logic [3:0] setup;   // [19:16]
      logic [3:0] turn;    // [15:12]
      logic [7:0] strobe;  // [11:4]
      logic [1:0] dhold;   // [3:2]
      logic [1:0] mode;    // [1:0]
   } wr_timing_t;

   // Decoded phase lengths, each stored as length minus one.
   typedef struct packed {
      logic             setup_en;
      logic             ahold_en;
      logic [CNT_W-1:0] setup_rl;
      logic [CNT_W-1:0] ahold_rl;
      logic [CNT_W-1:0] strobe_rl;
      logic [CNT_W-1:0] dhold_rl;
      logic [CNT_W-1:0] turn_rl;
   } phase_len_t;

   localparam wr_timing_t TIMING_RST = '{ahold: 4'hF, setup: 4'hF, turn: 4'hF,
                                         strobe: 8'hFF, dhold: 2'd0, mode: 2'd0};

endpackage

// File: rtl/awseq_cfg.sv
module awseq_cfg
   import awseq_pkg::*;
#(
   parameter logic [3:0] HOLD_MODES = 4'b1100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] timing_in,
   output phase_len_t       lens
);

   wr_timing_t held_q;
   wr_timing_t src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= TIMING_RST;
      else if (load) held_q <= wr_timing_t'(timing_in);
   end

   // The accepting cycle decodes the incoming word so the first phase is
   // loaded from it; later cycles decode the held copy.
   assign src = load ? wr_timing_t'(timing_in) : held_q;

   always_comb begin
      lens.setup_en  = (src.setup != 4'd0);
      lens.ahold_en  = HOLD_MODES[src.mode];
      lens.setup_rl  = CNT_W'(src.setup) - CNT_W'(1);
      lens.ahold_rl  = (src.ahold == 4'd0) ? '0 : CNT_W'(src.ahold) - CNT_W'(1);
      lens.strobe_rl = (src.strobe == 8'd0) ? '0 : CNT_W'(src.strobe) - CNT_W'(1);
      lens.dhold_rl  = CNT_W'(src.dhold);
      lens.turn_rl   = CNT_W'(src.turn);
   end

endmodule

// File: rtl/awseq_seq.sv
module awseq_seq
   import awseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  phase_len_t lens,
   output logic       accept,
   output phase_e     phase,
   output logic       ack
);

   logic [CNT_W-1:0] cnt_q;
   phase_e           first_ph;
   phase_e           nxt_ph;
   logic [CNT_W-1:0] rl_first;
   logic [CNT_W-1:0] rl_nxt;

   assign accept = (phase == PH_IDLE) && req && !ack;

   function automatic logic [CNT_W-1:0] reload_of(phase_e p, phase_len_t l);
      case (p)
         PH_SETUP:  reload_of = l.setup_rl;
         PH_AHOLD:  reload_of = l.ahold_rl;
         PH_STROBE: reload_of = l.strobe_rl;
         PH_DHOLD:  reload_of = l.dhold_rl;
         PH_TURN:   reload_of = l.turn_rl;
         default:   reload_of = '0;
      endcase
   endfunction

   always_comb begin
      if (lens.setup_en)      first_ph = PH_SETUP;
      else if (lens.ahold_en) first_ph = PH_AHOLD;
      else                    first_ph = PH_STROBE;
      case (phase)
         PH_SETUP:  nxt_ph = lens.ahold_en ? PH_AHOLD : PH_STROBE;
         PH_AHOLD:  nxt_ph = PH_STROBE;
         PH_STROBE: nxt_ph = PH_DHOLD;
         PH_DHOLD:  nxt_ph = PH_TURN;
         default:   nxt_ph = PH_IDLE;
      endcase
      rl_first = reload_of(first_ph, lens);
      rl_nxt   = reload_of(nxt_ph, lens);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
         ack   <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (phase == PH_IDLE) begin
            if (accept) begin
               phase <= first_ph;
               cnt_q <= rl_first;
            end
         end else if (cnt_q == '0) begin
            phase <= nxt_ph;
            cnt_q <= rl_nxt;
            if (nxt_ph == PH_IDLE) ack <= 1'b1;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/awseq_pins.sv
module awseq_pins
   import awseq_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  phase_e        phase,
   output logic          cs_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          adv_n,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic          data_oe
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   always_comb begin
      cs_n    = !(phase inside {PH_SETUP, PH_AHOLD, PH_STROBE, PH_DHOLD});
      adv_n   = !(phase inside {PH_SETUP, PH_AHOLD});
      we_n    = (phase != PH_STROBE);
      data_oe = (phase inside {PH_STROBE, PH_DHOLD});
      oe_n    = 1'b1;
   end

   assign addr_o = addr_q;

   generate
      if (PARK_ZERO) begin : g_park_zero
         assign data_o = data_oe ? data_q : '0;
      end else begin : g_park_hold
         assign data_o = data_q;
      end
   endgenerate

endmodule

// File: rtl/async_wr_seq.sv
module async_wr_seq
   import awseq_pkg::*;
#(
   parameter int         AW         = 16,
   parameter int         DW         = 16,
   parameter logic [3:0] HOLD_MODES = 4'b1100,
   parameter bit         PARK_ZERO  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic [23:0]   timing,
   output logic          ack,
   output logic          cs_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          adv_n,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic          data_oe
);

   if (AW < 1 || AW > 64) begin : g_bad_aw
      $error("async_wr_seq: AW out of range");
   end
   if (DW < 1 || DW > 128) begin : g_bad_dw
      $error("async_wr_seq: DW out of range");
   end
   if ($bits(wr_timing_t) != CFG_W) begin : g_bad_cfg
      $error("async_wr_seq: timing word layout mismatch");
   end

   logic       accept;
   phase_len_t lens;
   phase_e     phase;

   awseq_cfg #(.HOLD_MODES(HOLD_MODES)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .timing_in (timing),
      .lens      (lens)
   );

   awseq_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .lens   (lens),
      .accept (accept),
      .phase  (phase),
      .ack    (ack)
   );

   awseq_pins #(.AW(AW), .DW(DW), .PARK_ZERO(PARK_ZERO)) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .addr_in (req_addr),
      .data_in (req_data),
      .phase   (phase),
      .cs_n    (cs_n),
      .we_n    (we_n),
      .oe_n    (oe_n),
      .adv_n   (adv_n),
      .addr_o  (addr_o),
      .data_o  (data_o),
      .data_oe (data_oe)
   );

endmodule

// File: rtl/awseq_chk.sv
module awseq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic          cs_n,
   input logic          we_n,
   input logic          adv_n,
   input logic          data_oe,
   input logic [AW-1:0] addr_o
);

   a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !cs_n);

   a_r5_strobe_driven: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> data_oe);

   a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> data_oe);

   a_r2_adv_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n |-> (we_n && !data_oe && !cs_n));

   a_r6_release_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (!data_oe && we_n));

   a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   a_r6_ack_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (cs_n && !data_oe));

   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$past(cs_n)) |-> $stable(addr_o));

endmodule

bind async_wr_seq awseq_chk #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ack     (ack),
   .cs_n    (cs_n),
   .we_n    (we_n),
   .adv_n   (adv_n),
   .data_oe (data_oe),
   .addr_o  (addr_o)
);

// File: tb/sim_async_wr_seq.sv
module sim_async_wr_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [23:0]   timing = '0;
   logic          ack, cs_n, we_n, oe_n, adv_n, data_oe;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] data_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   async_wr_seq u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
      .req_data(req_data), .timing(timing), .ack(ack), .cs_n(cs_n),
      .we_n(we_n), .oe_n(oe_n), .adv_n(adv_n), .addr_o(addr_o),
      .data_o(data_o), .data_oe(data_oe)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic logic [23:0] mk(int ah, int su, int tu, int st, int dh, int md);
      return {4'(ah), 4'(su), 4'(tu), 8'(st), 2'(dh), 2'(md)};
   endfunction

   // One write; expected lengths derived from the requirement encodings.
   task automatic do_write(input logic [23:0] w, input logic [15:0] a,
                           input logic [15:0] d, input bit swap_cfg);
      int su = int'(w[19:16]);
      int md = int'(w[1:0]);
      int ah = (md >= 2) ? ((w[23:20] == 0) ? 1 : int'(w[23:20])) : 0;
      int st = (w[11:4] == 0) ? 1 : int'(w[11:4]);
      int dh = int'(w[3:2]) + 1;
      int tu = int'(w[15:12]) + 1;
      int n = 0, ncs = 0, nwe = 0, nadv = 0, ndoe = 0, nbad_ad = 0, noe = 0;
      @(negedge clk);
      timing = w; req_addr = a; req_data = d; req = 1'b1;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (swap_cfg && i == 0) timing = ~w;
         if (ack) break;
         n++;
         if (!cs_n) ncs++;
         if (!adv_n) nadv++;
         if (data_oe) ndoe++;
         if (!oe_n) noe++;
         if (!we_n) begin
            nwe++;
            if (addr_o != a || data_o != d) nbad_ad++;
         end
      end
      req = 1'b0;
      chk(ncs == su + ah + st + dh, "R2/R3/R4/R5 cs_n low cycles", ncs, su + ah + st + dh);
      chk(nadv == su + ah, "R2 R3 adv_n low cycles", nadv, su + ah);
      chk(nwe == st, "R4 we_n low cycles", nwe, st);
      chk(ndoe == st + dh, "R5 data_oe cycles", ndoe, st + dh);
      chk(n == su + ah + st + dh + tu, "R6 R7 R9 cycles before ack", n, su + ah + st + dh + tu);
      chk(nbad_ad == 0, "R8 addr/data during strobe", nbad_ad, 0);
      chk(noe == 0, "R9 oe_n low cycles", noe, 0);
      @(negedge clk);
      chk(cs_n && !ack && !data_oe && adv_n, "R1 R6 idle after ack", {cs_n, ack, data_oe, adv_n}, 4'b1001);
   endtask

   task automatic t_reset();
      chk(cs_n && we_n && oe_n && adv_n && !data_oe && !ack, "R1 reset pins",
          {cs_n, we_n, oe_n, adv_n, data_oe, ack}, 6'b111100);
   endtask

   task automatic t_full_default();  // R3 mode 2 with all long settings
      do_write(mk(15, 15, 15, 255, 0, 2), 16'hA5A5, 16'h1234, 1'b0);
   endtask

   task automatic t_no_setup();      // R2 zero setup, mode 0
      do_write(mk(7, 0, 0, 3, 1, 0), 16'h0F0F, 16'hBEEF, 1'b0);
   endtask

   task automatic t_zero_strobe();   // R4 zero strobe counted as 1
      do_write(mk(0, 2, 4, 0, 3, 1), 16'h1111, 16'h2222, 1'b0);
   endtask

   task automatic t_zero_ahold();    // R3 zero hold in mode 3 counted as 1
      do_write(mk(0, 1, 2, 5, 2, 3), 16'h3C3C, 16'h5A5A, 1'b0);
   endtask

   task automatic t_mode_b_skip();   // R3 hold field ignored in mode 1
      do_write(mk(9, 3, 1, 2, 0, 1), 16'h7777, 16'h8888, 1'b0);
   endtask

   task automatic t_cfg_change();    // R7 timing word altered after accept
      do_write(mk(2, 1, 3, 4, 1, 2), 16'hCAFE, 16'hF00D, 1'b1);
   endtask

   task automatic t_back_to_back();  // R9 two cycles, req held through each
      do_write(mk(1, 1, 0, 1, 0, 0), 16'h0001, 16'h0002, 1'b0);
      do_write(mk(1, 0, 0, 1, 0, 0), 16'h0003, 16'h0004, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_default();
      t_no_setup();
      t_zero_strobe();
      t_zero_ahold();
      t_mode_b_skip();
      t_cfg_change();
      t_back_to_back();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule